// File: doc/BRIEF.md
# Four-Channel Complementary PWM Generator with Dead-Time Insertion

This block produces pulse-width modulation on four channels from one shared 16-bit counter. Each channel drives a pair of outputs: a main output, active while the counter is below that channel's compare value, and a complementary output that is active during the rest of the cycle. A programmable gap is inserted on every switching edge. During the gap both outputs of the pair are inactive. This prevents shoot-through in half-bridge power stages.

The counter can run in two modes. In edge-aligned mode it counts upward and restarts. In center-aligned mode it sweeps up and then back down, which gives symmetric pulses and twice the cycle length for the same period value. The period, the compare values and the counting mode are captured into shadow copies only when a cycle ends. This lets software-style configuration inputs change at any time without producing a cut or stretched pulse. The gap length comes from an 8-bit code that selects one of four ranges with different step sizes, and a 2-bit divider then multiplies the result.

Top module: `cpwm_dt`

## Requirements
- R1: With `cfg_center` = 0 the counter runs 0, 1, …, period and restarts, so one PWM cycle lasts period+1 clocks. A channel's reference is active in each cycle in which the counter is strictly below its compare value.
- R2: A compare value of 0 keeps the main output inactive and the complementary output active for the whole cycle. A compare value of period+1 or more keeps the main output active and the complementary output inactive.
- R3: With `cfg_center` = 1 the counter runs 0 up to period and then back down to 1, so one cycle lasts 2×period clocks. For 1 ≤ compare ≤ period the reference is active for 2×compare−1 clocks per cycle.
- R4: After the reference rises, the main output becomes active only DT clocks later. After it falls, the complementary output becomes active only DT clocks later. Per cycle, the main output is therefore active for (reference active time − DT) clocks and the complementary output for (reference inactive time − DT) clocks.
- R5: If a reference pulse (active or inactive) lasts DT clocks or fewer, the output that would have been delayed stays inactive for that whole pulse.
- R6: The main and complementary outputs of a channel are never active in the same cycle.
- R7: The dead-time code is decoded into a base delay in ticks as follows. If code bit 7 is 0, the base is the code itself. If bits 7:6 are 10, the base is (64 + code[5:0])×2. If bits 7:5 are 110, the base is (32 + code[4:0])×8. If bits 7:5 are 111, the base is (32 + code[4:0])×16.
- R8: `cfg_dt_div` scales the tick length. A value of 0 gives 1 clock per tick, 1 gives 2 clocks, and 2 or 3 give 4 clocks. DT in clocks is the base from R7 times this factor.
- R9: The period, compare values and counting mode take effect only at the end of the current PWM cycle. A compare change made in the middle of a pulse does not alter that pulse's width.
- R10: While a channel's enable bit is 0, both of its outputs are held at the inactive level.
- R11: A polarity bit of 0 makes both outputs of that channel active-high. A polarity bit of 1 makes both active-low.
- R12: While `rst` is high, all outputs are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | 16 | Counter top value (shadowed) |
| cfg_center | input | 1 | 1 = center-aligned up/down counting (shadowed) |
| cfg_compare | input | 64 | Compare value per channel, channel n in bits 16n+15:16n (shadowed) |
| cfg_enable | input | 4 | Per-channel output enable |
| cfg_polarity | input | 4 | Per-channel polarity, 1 = active-low |
| cfg_dt_div | input | 2 | Dead-time tick divider selection |
| cfg_dt_code | input | 8 | Encoded dead-time length |
| pwm_main | output | 4 | Main output per channel |
| pwm_comp | output | 4 | Complementary output per channel |

## Verification
Assertions watch several relations on every clock. The counter never passes the shadowed period, and a down sweep stays between 1 and period−1. Every cycle end restarts the counter at zero. Both outputs of a pair are inactive right after each reference edge when the gap is non-zero. Each output is only active while the reference level matches it. A disabled channel sits at its inactive level. Only the bench's scenarios show the numeric results: active times per cycle under both counting modes, the dead-time decoding across all four code ranges and the divider, suppression of short pulses, polarity, and the fact that a compare change made mid-pulse waits for the next cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int DT_CODE_W = 8;
  localparam int DT_DIV_W  = 2;
  localparam int DT_BASE_W = 10;            // largest base delay is 1008 ticks
  localparam int DT_W      = DT_BASE_W + 2; // up to four clocks per tick

  typedef enum logic {CNT_UP = 1'b0, CNT_DN = 1'b1} cnt_dir_e;

  typedef enum logic [1:0] {
    DTDIV_1  = 2'd0,
    DTDIV_2  = 2'd1,
    DTDIV_4  = 2'd2,
    DTDIV_4B = 2'd3
  } dt_div_e;
endpackage

// File: rtl/cpwm_dt_decode.sv
module cpwm_dt_decode
  import cpwm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DT_CODE_W-1:0] code,
  input  logic [DT_DIV_W-1:0]  div,
  output logic [DT_W-1:0]      delay
);
  logic [DT_BASE_W-1:0] base;
  logic [DT_W-1:0]      scaled;

  // R7: four ranges, each with a coarser step
  always_comb begin
    if (!code[7])      base = DT_BASE_W'(code);
    else if (!code[6]) base = DT_BASE_W'({1'b1, code[5:0], 1'b0});
    else if (!code[5]) base = DT_BASE_W'({1'b1, code[4:0], 3'b000});
    else               base = {1'b1, code[4:0], 4'b0000};
  end

  // R8: tick length in clocks
  always_comb begin
    case (dt_div_e'(div))
      DTDIV_1: scaled = DT_W'(base);
      DTDIV_2: scaled = DT_W'(base) << 1;
      default: scaled = DT_W'(base) << 2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) delay <= '0;
    else     delay <= scaled;
  end
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_in,
  input  logic          center_in,
  output logic [CW-1:0] cnt,
  output logic          load
);
  logic          primed;
  logic          ctr_sh;
  logic [CW-1:0] per_sh;
  cnt_dir_e      dir;
  logic          wrap;

  always_comb begin
    if (!ctr_sh)          wrap = (cnt >= per_sh);
    else if (dir == CNT_UP) wrap = (per_sh <= CW'(1)) && (cnt >= per_sh);
    else                  wrap = (cnt <= CW'(1));
  end

  assign load = !primed || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      cnt    <= '0;
      dir    <= CNT_UP;
      per_sh <= '0;
      ctr_sh <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (load) begin
        cnt    <= '0;
        dir    <= CNT_UP;
        per_sh <= period_in;
        ctr_sh <= center_in;
      end else if (ctr_sh && dir == CNT_UP && cnt >= per_sh) begin
        dir <= CNT_DN;
        cnt <= per_sh - CW'(1);
      end else if (dir == CNT_UP) begin
        cnt <= cnt + CW'(1);
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    primed |-> (cnt <= per_sh));

  assert_load_restart_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0 && dir == CNT_UP));

  assert_down_sweep_R3: assert property (@(posedge clk) disable iff (rst)
    (dir == CNT_DN) |-> (ctr_sh && cnt >= CW'(1) && cnt < per_sh));
endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband
  import cpwm_pkg::*;
#(
  parameter int DW = DT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic [DW-1:0] delay,
  output logic          main_act,
  output logic          comp_act
);
  logic          ref_q;
  logic          armed;
  logic [DW-1:0] hold;
  logic          edge_seen;

  // the first cycle after reset counts as an edge so neither output starts early
  assign edge_seen = (ref_in ^ ref_q) || !armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q    <= 1'b0;
      armed    <= 1'b0;
      hold     <= '0;
      main_act <= 1'b0;
      comp_act <= 1'b0;
    end else begin
      ref_q <= ref_in;
      armed <= 1'b1;
      if (edge_seen && delay != '0) begin
        hold     <= delay;
        main_act <= 1'b0;
        comp_act <= 1'b0;
      end else if (!edge_seen && hold > DW'(1)) begin
        hold <= hold - DW'(1);
      end else begin
        hold     <= '0;
        main_act <= ref_in;
        comp_act <= !ref_in;
      end
    end
  end

  assert_gap_after_edge_R4: assert property (@(posedge clk) disable iff (rst)
    (armed && (ref_in ^ ref_q) && delay != '0) |=> (!main_act && !comp_act));

  assert_main_tracks_ref_R6: assert property (@(posedge clk) disable iff (rst)
    main_act |-> $past(ref_in));

  assert_comp_tracks_ref_R6: assert property (@(posedge clk) disable iff (rst)
    comp_act |-> !$past(ref_in));
endmodule

// File: rtl/cpwm_dt.sv
module cpwm_dt
  import cpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cfg_period,
  input  logic              cfg_center,
  input  logic [NCH*CW-1:0] cfg_compare,
  input  logic [NCH-1:0]    cfg_enable,
  input  logic [NCH-1:0]    cfg_polarity,
  input  logic [1:0]        cfg_dt_div,
  input  logic [7:0]        cfg_dt_code,
  output logic [NCH-1:0]    pwm_main,
  output logic [NCH-1:0]    pwm_comp
);
  logic [CW-1:0]            cnt;
  logic                     load;
  logic [DT_W-1:0]          delay;
  logic [NCH-1:0][CW-1:0]   cmp_sh;
  logic [NCH-1:0]           ref_v;
  logic [NCH-1:0]           main_act;
  logic [NCH-1:0]           comp_act;
  logic                     started;

  cpwm_timebase #(.CW(CW)) i_timebase (
    .clk       (clk),
    .rst       (rst),
    .period_in (cfg_period),
    .center_in (cfg_center),
    .cnt       (cnt),
    .load      (load)
  );

  cpwm_dt_decode i_dt_decode (
    .clk   (clk),
    .rst   (rst),
    .code  (cfg_dt_code),
    .div   (cfg_dt_div),
    .delay (delay)
  );

  // R9: compare values move into the shadow only at a cycle boundary
  always_ff @(posedge clk) begin
    if (rst)       cmp_sh <= '0;
    else if (load) cmp_sh <= cfg_compare;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign ref_v[ch] = (cnt < cmp_sh[ch]);

    cpwm_deadband #(.DW(DT_W)) i_deadband (
      .clk      (clk),
      .rst      (rst),
      .ref_in   (ref_v[ch]),
      .delay    (delay),
      .main_act (main_act[ch]),
      .comp_act (comp_act[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_main <= '0;
      pwm_comp <= '0;
      started  <= 1'b0;
    end else begin
      pwm_main <= (main_act & cfg_enable) ^ cfg_polarity;
      pwm_comp <= (comp_act & cfg_enable) ^ cfg_polarity;
      started  <= 1'b1;
    end
  end

  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (rst)
    started |-> ((((pwm_main ^ $past(cfg_polarity)) | (pwm_comp ^ $past(cfg_polarity)))
                 & ~$past(cfg_enable)) == '0));

  assert_pair_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    started |-> (((pwm_main ^ $past(cfg_polarity)) & (pwm_comp ^ $past(cfg_polarity))) == '0));
endmodule

// File: tb/test_cpwm_dt.sv
module test_cpwm_dt;
  localparam int NCH = 4;
  localparam int CW  = 16;

  typedef struct packed {
    int                 win;
    logic [3:0]         pol;
    logic [3:0][31:0]   mhi;
    logic [3:0][31:0]   chi;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CW-1:0]     cfg_period = '0;
  logic              cfg_center = 1'b0;
  logic [NCH*CW-1:0] cfg_compare = '0;
  logic [NCH-1:0]    cfg_enable = '0;
  logic [NCH-1:0]    cfg_polarity = '0;
  logic [1:0]        cfg_dt_div = '0;
  logic [7:0]        cfg_dt_code = '0;
  logic [NCH-1:0]    pwm_main;
  logic [NCH-1:0]    pwm_comp;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cyc = 0;
  bit    busy = 1'b0;
  item_t item_q[$];
  string tag_q[$];

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  cpwm_dt #(.NCH(NCH), .CW(CW)) i_cpwm_dt (
    .clk          (clk),
    .rst          (rst),
    .cfg_period   (cfg_period),
    .cfg_center   (cfg_center),
    .cfg_compare  (cfg_compare),
    .cfg_enable   (cfg_enable),
    .cfg_polarity (cfg_polarity),
    .cfg_dt_div   (cfg_dt_div),
    .cfg_dt_code  (cfg_dt_code),
    .pwm_main     (pwm_main),
    .pwm_comp     (pwm_comp)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R7 and R8 written from the requirement text
  function automatic int dt_clocks(input int code, input int div);
    int b;
    if (code < 128)      b = code;
    else if (code < 192) b = (64 + code - 128) * 2;
    else if (code < 224) b = (32 + code - 192) * 8;
    else                 b = (32 + code - 224) * 16;
    return b * ((div == 0) ? 1 : (div == 1) ? 2 : 4);
  endfunction

  // active clocks per cycle from R1..R5, then enable (R10) and polarity (R11)
  function automatic void expect_ch(input int per, input bit ctr, input int c, input int dt,
                                    input bit en, input bit pol, output int mh, output int chh);
    int len, ra, ma, ca;
    len = ctr ? 2 * per : per + 1;
    if (ctr) ra = (c == 0) ? 0 : (c > per) ? 2 * per : 2 * c - 1;
    else     ra = (c > per) ? per + 1 : c;
    if (ra == 0)        begin ma = 0;   ca = len; end
    else if (ra == len) begin ma = len; ca = 0;   end
    else begin
      ma = (ra > dt) ? ra - dt : 0;
      ca = (len - ra > dt) ? len - ra - dt : 0;
    end
    if (!en) begin ma = 0; ca = 0; end
    mh  = pol ? len - ma : ma;
    chh = pol ? len - ca : ca;
  endfunction

  task automatic run_case(input string tag, input int per, input bit ctr, input int cmp[4],
                          input bit [3:0] en, input bit [3:0] pol, input int code,
                          input int div, input int k);
    item_t it;
    int dt, len, mh, chh;
    @(negedge clk);
    cfg_period   = per[CW-1:0];
    cfg_center   = ctr;
    for (int ch = 0; ch < NCH; ch++) cfg_compare[ch*CW +: CW] = cmp[ch][CW-1:0];
    cfg_enable   = en;
    cfg_polarity = pol;
    cfg_dt_code  = code[7:0];
    cfg_dt_div   = div[1:0];
    repeat (2200) @(negedge clk);
    dt  = dt_clocks(code, div);
    len = ctr ? 2 * per : per + 1;
    for (int ch = 0; ch < NCH; ch++) begin
      expect_ch(per, ctr, cmp[ch], dt, en[ch], pol[ch], mh, chh);
      it.mhi[ch] = mh * k;
      it.chi[ch] = chh * k;
    end
    it.win = len * k;
    it.pol = pol;
    busy = 1'b1;
    tag_q.push_back(tag);
    item_q.push_back(it);
    wait (busy == 1'b0);
  endtask

  // monitor: counts output levels over whole cycles and compares with the queue
  initial begin
    item_t it;
    string tg;
    int    mc[4];
    int    cc[4];
    int    ov;
    forever begin
      wait (item_q.size() != 0);
      it = item_q.pop_front();
      tg = tag_q.pop_front();
      for (int ch = 0; ch < NCH; ch++) begin mc[ch] = 0; cc[ch] = 0; end
      ov = 0;
      repeat (it.win) begin
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) begin
          if (pwm_main[ch]) mc[ch]++;
          if (pwm_comp[ch]) cc[ch]++;
          if ((pwm_main[ch] ^ it.pol[ch]) && (pwm_comp[ch] ^ it.pol[ch])) ov++;
        end
      end
      for (int ch = 0; ch < NCH; ch++) begin
        chk($sformatf("%s ch%0d main high clocks", tg, ch), mc[ch], int'(it.mhi[ch]));
        chk($sformatf("%s ch%0d comp high clocks", tg, ch), cc[ch], int'(it.chi[ch]));
      end
      chk($sformatf("%s R6 overlap clocks", tg), ov, 0);
      busy = 1'b0;
    end
  end

  task automatic wait_rise(output int t);
    do @(negedge clk); while (pwm_main[0]);
    do @(negedge clk); while (!pwm_main[0]);
    t = cyc;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    int t0, t1, w;
    repeat (5) @(negedge clk);
    chk("R12 main during reset", int'(pwm_main), 0);
    chk("R12 comp during reset", int'(pwm_comp), 0);
    rst = 1'b0;

    run_case("R1 R2 edge no gap", 49, 1'b0, '{0, 20, 35, 60}, 4'hF, 4'h0, 0, 0, 2);
    run_case("R4 R7 edge gap 5", 99, 1'b0, '{10, 50, 70, 100}, 4'hF, 4'h0, 5, 0, 2);
    run_case("R3 R5 center gap 3", 50, 1'b1, '{0, 1, 25, 51}, 4'hF, 4'h0, 3, 0, 2);
    run_case("R7 code 0x81", 999, 1'b0, '{500, 200, 131, 900}, 4'hF, 4'h0, 8'h81, 0, 1);
    run_case("R5 R7 code 0xC1", 999, 1'b0, '{264, 300, 600, 999}, 4'hF, 4'h0, 8'hC1, 0, 1);
    run_case("R7 code 0xE0", 999, 1'b0, '{100, 500, 900, 1000}, 4'hF, 4'h0, 8'hE0, 0, 1);
    run_case("R8 div 2", 199, 1'b0, '{100, 30, 170, 60}, 4'hF, 4'h0, 10, 2, 2);
    run_case("R8 R11 div 3 polarity", 199, 1'b0, '{100, 30, 170, 60}, 4'hF, 4'h5, 10, 3, 2);
    run_case("R8 div 1 center", 40, 1'b1, '{20, 5, 39, 41}, 4'hF, 4'h0, 3, 1, 2);
    run_case("R10 enable mask", 99, 1'b0, '{30, 30, 70, 70}, 4'hA, 4'hC, 4, 0, 2);

    // R9 and R1: a compare change in mid-pulse waits for the next cycle
    @(negedge clk);
    cfg_period   = 16'd99;
    cfg_center   = 1'b0;
    cfg_enable   = 4'hF;
    cfg_polarity = 4'h0;
    cfg_dt_code  = 8'd0;
    cfg_dt_div   = 2'd0;
    for (int ch = 0; ch < NCH; ch++) cfg_compare[ch*CW +: CW] = 16'd40;
    repeat (2200) @(negedge clk);
    wait_rise(t0);
    w = 1;
    while (1) begin
      @(negedge clk);
      if (!pwm_main[0]) break;
      w++;
      if (w == 5) cfg_compare[CW-1:0] = 16'd80;
    end
    chk("R9 pulse width during change", w, 40);
    wait_rise(t1);
    w = 1;
    while (1) begin
      @(negedge clk);
      if (!pwm_main[0]) break;
      w++;
    end
    chk("R9 pulse width after change", w, 80);
    chk("R1 cycle length", t1 - t0, 100);

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule